// File: doc/BRIEF.md
# Debug Bus Access Arbiter

This block decides in which cycle a memory access started by the debug port is placed on the system bus. A debug request is captured into a single pending slot. Each cycle the block chooses between two policies. In the first, the access is granted in the cycle right after capture. In the second, the access waits until the CPU side reports a free bus cycle. The second policy is used only when handshaking is enabled and stealing is not selected. In every other combination of the two inputs the first policy applies.

A wait for a free cycle is bounded. If the bus has not come free by the 512th cycle after the request, the access is forced onto the bus. A one-cycle timeout indication is raised alongside that forced grant.

Separately, the block keeps a long-handshake flag. The flag is armed when stop mode is entered while handshaking and the stop-continue option are both on. It is dropped once the first handshake after that entry has completed. The bus fabric and the handshake pulse generator sit outside the block.

Top module: `dbg_bus_arbiter`

## Requirements
- R1: After a synchronous reset, `grant_o`, `timeout_o` and `long_ack_o` are 0, and any request pending before the reset is discarded, so no grant follows it.
- R2: With `ack_en_i`=0, a request captured at a clock edge produces `grant_o`=1 in the cycle that follows that edge. This holds for either value of `steal_i` and for either value of `bus_free_i`.
- R3: With `ack_en_i`=1 and `steal_i`=1, a captured request is granted in the cycle after capture, whatever `bus_free_i` is.
- R4: With `ack_en_i`=1 and `steal_i`=0, a pending request is granted in the first cycle in which `bus_free_i`=1. It is not granted in any earlier cycle, unless the timeout of R5 applies.
- R5: In the wait policy, when the bus never comes free, `grant_o` and `timeout_o` rise together in the 512th cycle after the request cycle. If the bus comes free in exactly that cycle, the grant is an ordinary one and `timeout_o` stays 0.
- R6: `timeout_o` is high for a single cycle and only in a cycle where `grant_o` is also high.
- R7: The wait count starts from zero for each newly accepted request, so a request that follows a timed-out one again waits the full 512 cycles.
- R8: Only one access is outstanding at a time. A request seen while one is pending, including in the cycle of its grant, is ignored. It neither adds a grant nor restarts the wait count.
- R9: A grant lasts exactly one cycle and retires the pending request. The following cycle has `grant_o`=0 unless a new request has been accepted.
- R10: A `stop_entry_i` pulse with `ack_en_i`=1 and `stop_cont_i`=1 sets `long_ack_o` from the next cycle on.
- R11: A `stop_entry_i` pulse while `ack_en_i` or `stop_cont_i` is 0 leaves `long_ack_o` at 0.
- R12: An `ack_done_i` pulse clears `long_ack_o` from the next cycle on. If a qualifying stop entry arrives in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Debug access request, sampled at each rising edge |
| bus_free_i | input | 1 | CPU side reports that the current bus cycle is unused |
| ack_en_i | input | 1 | Handshaking enabled |
| steal_i | input | 1 | Issue accesses immediately when handshaking is on |
| stop_entry_i | input | 1 | One-cycle pulse on stop-mode entry |
| stop_cont_i | input | 1 | Stop-continue option active |
| ack_done_i | input | 1 | One-cycle pulse when a handshake pulse has completed |
| grant_o | output | 1 | Perform the pending access in this cycle |
| timeout_o | output | 1 | Grant in this cycle was forced by the wait limit |
| long_ack_o | output | 1 | Next handshake pulse must be the long variety |

## Verification
The embedded assertions check several things on every cycle. They check that a grant never lasts two cycles and that a grant retires the pending slot. They check that a timeout only accompanies a grant, that a waiting request is held back while the bus is busy and the limit is not reached, and that the long-handshake flag only rises after a qualifying stop entry. The bench's scenarios are what show the actual grant latencies under each policy, including the exact 511/512 boundary. They also show that a second request during a wait does not restart the count, that the count starts over for a later request, and that the flag's set-over-clear priority holds.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

    // Grant policy chosen each cycle from the handshake controls.
    typedef enum logic [0:0] {
        POL_NEXT_CYCLE = 1'b0,
        POL_WAIT_FREE  = 1'b1
    } policy_e;

    // Result of the per-cycle grant decision.
    typedef struct packed {
        logic grant;
        logic forced;
    } issue_t;

    localparam int unsigned DEFAULT_WAIT_LIMIT = 512;

    // Waiting for a free slot only applies with handshaking on and steal off.
    function automatic policy_e pick_policy(input logic ack_en, input logic steal);
        return (ack_en && !steal) ? POL_WAIT_FREE : POL_NEXT_CYCLE;
    endfunction

    function automatic issue_t decide(input logic    pending,
                                      input policy_e pol,
                                      input logic    bus_free,
                                      input logic    expired);
        issue_t r;
        r.grant  = 1'b0;
        r.forced = 1'b0;
        if (pending) begin
            if (pol == POL_NEXT_CYCLE) begin
                r.grant = 1'b1;
            end else if (bus_free) begin
                r.grant = 1'b1;
            end else if (expired) begin
                r.grant  = 1'b1;
                r.forced = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dbg_req_tracker.sv
module dbg_req_tracker (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic grant_i,
    output logic pend_o,
    output logic accept_o
);
    logic pend_q;

    // A new request is only taken when the slot is empty (R8).
    assign accept_o = req_i && !pend_q;
    assign pend_o   = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (grant_i) begin
            pend_q <= 1'b0;
        end else if (accept_o) begin
            pend_q <= 1'b1;
        end
    end

    // R9: a grant retires the slot
    assert_grant_retires_R9: assert property (@(posedge clk) disable iff (rst)
        grant_i |=> !pend_q);

    // R8: an accepted request occupies the slot
    assert_accept_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (accept_o && !grant_i) |=> pend_q);

endmodule

// File: rtl/dbg_wait_timer.sv
module dbg_wait_timer #(
    parameter int unsigned LIMIT = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: each accepted request starts counting from zero
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt_q == '0));

    // R5: the count never passes the limit
    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/dbg_longack_flag.sv
module dbg_longack_flag (
    input  logic clk,
    input  logic rst,
    input  logic stop_entry_i,
    input  logic ack_en_i,
    input  logic stop_cont_i,
    input  logic ack_done_i,
    output logic long_o
);
    logic flag_q;
    logic arm;

    assign arm    = stop_entry_i && ack_en_i && stop_cont_i;
    assign long_o = flag_q;

    // Arming wins over clearing in the same cycle (R12).
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (arm) begin
            flag_q <= 1'b1;
        end else if (ack_done_i) begin
            flag_q <= 1'b0;
        end
    end

    // R10, R11: the flag only rises after a qualifying stop entry
    assert_rise_qualified_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(stop_entry_i && ack_en_i && stop_cont_i));

    // R12: a completed handshake without re-arming drops the flag
    assert_done_clears_R12: assert property (@(posedge clk) disable iff (rst)
        (ack_done_i && !(stop_entry_i && ack_en_i && stop_cont_i)) |=> !flag_q);

endmodule

// File: rtl/dbg_bus_arbiter.sv
module dbg_bus_arbiter
    import dbg_arb_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = DEFAULT_WAIT_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic bus_free_i,
    input  logic ack_en_i,
    input  logic steal_i,
    input  logic stop_entry_i,
    input  logic stop_cont_i,
    input  logic ack_done_i,
    output logic grant_o,
    output logic timeout_o,
    output logic long_ack_o
);
    logic    pend_w;
    logic    accept_w;
    logic    expired_w;
    policy_e pol_w;
    issue_t  issue_w;

    dbg_req_tracker u_tracker (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .grant_i  (issue_w.grant),
        .pend_o   (pend_w),
        .accept_o (accept_w)
    );

    dbg_wait_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (accept_w),
        .run_i     (pend_w && !issue_w.grant),
        .expired_o (expired_w)
    );

    dbg_longack_flag u_longack (
        .clk          (clk),
        .rst          (rst),
        .stop_entry_i (stop_entry_i),
        .ack_en_i     (ack_en_i),
        .stop_cont_i  (stop_cont_i),
        .ack_done_i   (ack_done_i),
        .long_o       (long_ack_o)
    );

    always_comb begin
        pol_w   = pick_policy(ack_en_i, steal_i);
        issue_w = decide(pend_w, pol_w, bus_free_i, expired_w);
    end

    assign grant_o   = issue_w.grant;
    assign timeout_o = issue_w.forced;

    // R9: single-cycle grant
    assert_grant_single_R9: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> !grant_o);

    // R6: timeout only accompanies a grant, and lasts one cycle
    assert_timeout_with_grant_R6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> grant_o);
    assert_timeout_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    // R4: a waiting request stays held while the bus is busy and the limit is not reached
    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (pend_w && ack_en_i && !steal_i && !bus_free_i && !expired_w) |-> !grant_o);

    // R2, R3: immediate policies never leave a pending request ungranted
    assert_next_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_w && (!ack_en_i || steal_i)) |-> grant_o);

endmodule

// File: tb/dbg_bus_arbiter_tb.sv
module dbg_bus_arbiter_tb;

    localparam int NEVER = 100000;

    typedef struct packed {
        logic ack;
        logic steal;
        int   freeat;
        int   lat;
        logic to;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, NEVER, 1,   1'b0},  // R2
        '{1'b0, 1'b1, NEVER, 1,   1'b0},  // R2
        '{1'b0, 1'b0, 0,     1,   1'b0},  // R2
        '{1'b1, 1'b1, NEVER, 1,   1'b0},  // R3
        '{1'b1, 1'b0, 0,     1,   1'b0},  // R4
        '{1'b1, 1'b0, 5,     5,   1'b0},  // R4
        '{1'b1, 1'b0, 511,   511, 1'b0},  // R4 boundary
        '{1'b1, 1'b0, 512,   512, 1'b0},  // R5 free at limit
        '{1'b1, 1'b0, NEVER, 512, 1'b1},  // R5
        '{1'b1, 1'b0, NEVER, 512, 1'b1}   // R7 restart
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 1'b0, bus_free_i = 1'b0, ack_en_i = 1'b0, steal_i = 1'b0;
    logic stop_entry_i = 1'b0, stop_cont_i = 1'b0, ack_done_i = 1'b0;
    logic grant_o, timeout_o, long_ack_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dbg_bus_arbiter u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .bus_free_i(bus_free_i),
        .ack_en_i(ack_en_i), .steal_i(steal_i), .stop_entry_i(stop_entry_i),
        .stop_cont_i(stop_cont_i), .ack_done_i(ack_done_i),
        .grant_o(grant_o), .timeout_o(timeout_o), .long_ack_o(long_ack_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Inputs change just after a rising edge; outputs are read at the falling edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Issues one request in cycle 0 and reports the cycle of its grant.
    task automatic run_req(input logic ack, input logic steal, input int freeat,
                           input int second_req_at, output int lat, output int to);
        lat = -1;
        to  = 0;
        tick();
        ack_en_i   = ack;
        steal_i    = steal;
        req_i      = 1'b1;
        bus_free_i = (freeat == 0);
        @(negedge clk);
        for (int cyc = 1; cyc <= 700; cyc++) begin
            tick();
            req_i      = (cyc == second_req_at);
            bus_free_i = (cyc >= freeat);
            @(negedge clk);
            if (grant_o) begin
                lat = cyc;
                to  = timeout_o;
                break;
            end
        end
        tick();
        req_i      = 1'b0;
        bus_free_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int lat, to, grants;

        repeat (3) tick();
        @(negedge clk);
        chk("R1 grant at reset", grant_o, 0);
        chk("R1 timeout at reset", timeout_o, 0);
        chk("R1 long_ack at reset", long_ack_o, 0);
        tick();
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_req(VECS[i].ack, VECS[i].steal, VECS[i].freeat, -1, lat, to);
            chk($sformatf("R2-5 vec%0d latency", i), lat, VECS[i].lat);
            chk($sformatf("R6 vec%0d timeout", i), to, int'(VECS[i].to));
            // The cycle after the grant has no grant and no timeout.
            chk($sformatf("R9 vec%0d grant after", i), grant_o, 0);
            chk($sformatf("R6 vec%0d timeout after", i), timeout_o, 0);
        end

        // R8: a second request while waiting neither restarts the count nor adds a grant.
        run_req(1'b1, 1'b0, NEVER, 100, lat, to);
        chk("R8 latency with extra req", lat, 512);
        chk("R8 timeout with extra req", to, 1);
        grants = 0;
        for (int c = 0; c < 20; c++) begin
            tick();
            bus_free_i = 1'b1;
            @(negedge clk);
            grants += int'(grant_o);
        end
        bus_free_i = 1'b0;
        chk("R8 no extra grant", grants, 0);

        // R8: a request in the grant cycle is ignored.
        tick();
        ack_en_i = 1'b1; steal_i = 1'b1; req_i = 1'b1;
        @(negedge clk);
        tick();
        @(negedge clk);
        chk("R8 grant while req held", grant_o, 1);
        tick();
        req_i = 1'b0;
        @(negedge clk);
        chk("R8 req in grant cycle ignored", grant_o, 0);

        // R1: reset discards a pending request.
        tick();
        steal_i = 1'b0; req_i = 1'b1;
        tick();
        req_i = 1'b0; rst = 1'b1;
        tick();
        rst = 1'b0;
        grants = 0;
        for (int c = 0; c < 600; c++) begin
            tick();
            bus_free_i = 1'b1;
            @(negedge clk);
            grants += int'(grant_o);
        end
        bus_free_i = 1'b0;
        chk("R1 pending dropped by reset", grants, 0);

        // R10..R12: long handshake flag.
        tick();
        ack_en_i = 1'b1; stop_cont_i = 1'b0; stop_entry_i = 1'b1;
        tick();
        stop_entry_i = 1'b0;
        @(negedge clk);
        chk("R11 no set without stop_cont", long_ack_o, 0);
        tick();
        ack_en_i = 1'b0; stop_cont_i = 1'b1; stop_entry_i = 1'b1;
        tick();
        stop_entry_i = 1'b0;
        @(negedge clk);
        chk("R11 no set without ack_en", long_ack_o, 0);
        tick();
        ack_en_i = 1'b1; stop_entry_i = 1'b1;
        @(negedge clk);
        chk("R10 not yet set", long_ack_o, 0);
        tick();
        stop_entry_i = 1'b0;
        @(negedge clk);
        chk("R10 set after stop entry", long_ack_o, 1);
        repeat (3) tick();
        @(negedge clk);
        chk("R10 holds", long_ack_o, 1);
        ack_done_i = 1'b1; stop_entry_i = 1'b1;
        tick();
        ack_done_i = 1'b0; stop_entry_i = 1'b0;
        @(negedge clk);
        chk("R12 set wins over clear", long_ack_o, 1);
        ack_done_i = 1'b1;
        tick();
        ack_done_i = 1'b0;
        @(negedge clk);
        chk("R12 cleared by ack_done", long_ack_o, 0);
        stop_entry_i = 1'b1;
        tick();
        stop_entry_i = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset clears long_ack", long_ack_o, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule